// File: doc/BRIEF.md
# Pixel Event Packet Formatter

This block frames the hit pattern of one triggered event from a binary pixel readout chip into a packet of 32-bit words for a downstream serial link. The event's data words arrive on a valid/ready input. The block emits them on a valid/ready output, framed by two header words in front and one trailer word at the end. The headers carry an event count, a bunch identifier, a detector identifier, front-end status flags, the run mode and an overflow flag. The trailer holds one parity bit for each bit column of the payload, so that a receiver can test the link's integrity.

There are two run modes. In the grouped mode, eight pixels are OR-ed into one hit, which gives an effective 32x32 array and a payload of 32 words. In the full-resolution diagnostic mode, every pixel of the 256x32 array is read, which gives a payload of 256 words. The mode and all header inputs are captured once, when a packet starts. The payload words pass through with no added latency. Headers and the trailer are inserted by stalling the input.

Top module: `pix_evt_framer`

## Requirements
- R1: While reset is asserted and directly after it, `out_valid` and `in_ready` are 0.
- R2: Every packet is emitted as header 0 (with `out_sop`=1), then header 1, then the payload, then the trailer (with `out_eop`=1). `out_sop` and `out_eop` are 0 on every other word. After the trailer is accepted, `out_valid` is 0 for at least one cycle.
- R3: Header 0 is {event count[31:24], bunch id[23:12], detector id[11:8], status[7:0]}.
- R4: Header 1 is {mode[31] (1 = full resolution), overflow[30], zero[29:0]}.
- R5: With `full_mode`=0 at packet start, exactly 32 payload words are taken from the input and emitted unchanged, in order.
- R6: With `full_mode`=1 at packet start, exactly 256 payload words are taken and emitted unchanged, in order.
- R7: Trailer bit i is the XOR of bit i over all payload words of that packet only. The accumulation restarts at every packet.
- R8: `full_mode`, bunch id, detector id, status and overflow are sampled in the cycle the packet starts, which is the first cycle in idle with `in_valid`=1. Changes to them later in the packet do not affect that packet's headers or length.
- R9: The event count is 0 for the first packet after reset, rises by one for each completed packet, and wraps from 255 to 0.
- R10: While `out_valid`=1 and `out_ready`=0, the next cycle still has `out_valid`=1, with `out_data`, `out_sop` and `out_eop` unchanged.
- R11: `in_ready` is 1 only while a payload word is being presented. It is 0 during the headers, the trailer and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_mode | input | 1 | 1 selects the 256-word full-resolution payload |
| bunch_id | input | 12 | Bunch identifier for header 0 |
| det_id | input | 4 | Detector identifier for header 0 |
| fe_status | input | 8 | Front-end status flags for header 0 |
| ovf_flag | input | 1 | Overflow flag for header 1 |
| in_valid | input | 1 | Payload word available |
| in_ready | output | 1 | Payload word accepted this cycle when both are high |
| in_data | input | 32 | Payload word |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Output word |
| out_sop | output | 1 | Marks header 0 |
| out_eop | output | 1 | Marks the trailer |

## Verification
The payloads tried are all zeros, all ones, a walking single bit, a multiplicative hash sequence and a payload with a single all-ones word. All-ones over an even word count gives a zero trailer, and the single-word pattern gives an all-ones trailer, so together they show whether the parity is accumulated per column, cleared between packets and covers exactly the right words. Both modes are run with the downstream always ready and with random stalls. The stalls separate a design that holds its word from one that advances anyway. Every header input and the mode are inverted right after each packet starts, which exposes any sampling that happens after the start. A run of over 256 packets makes the event count wrap.

// File: rtl/pfmt_pkg.sv
package pfmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR0 = 3'd1,
    ST_HDR1 = 3'd2,
    ST_PAY  = 3'd3,
    ST_TRL  = 3'd4
  } pfmt_state_e;
endpackage

// File: rtl/pfmt_ctrl.sv
module pfmt_ctrl
  import pfmt_pkg::*;
#(
  parameter int NORM_WORDS = 32,
  parameter int FULL_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        out_ready,
  input  logic        full_mode,
  output pfmt_state_e state,
  output logic        start,
  output logic        pay_fire,
  output logic        pkt_done,
  output logic        mode_q
);
  localparam int CW = (FULL_WORDS > NORM_WORDS) ? $clog2(FULL_WORDS) : $clog2(NORM_WORDS);
  localparam logic [CW-1:0] LAST_FULL = CW'(FULL_WORDS - 1);
  localparam logic [CW-1:0] LAST_NORM = CW'(NORM_WORDS - 1);

  pfmt_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          mode_d, mode_en;
  logic          pay_last;

  always_comb begin
    state_d  = state_q;
    start    = 1'b0;
    pkt_done = 1'b0;
    pay_fire = (state_q == ST_PAY) && in_valid && out_ready;
    pay_last = (cnt_q == (mode_q ? LAST_FULL : LAST_NORM));
    case (state_q)
      ST_IDLE: if (in_valid) begin
        start   = 1'b1;
        state_d = ST_HDR0;
      end
      ST_HDR0: if (out_ready) state_d = ST_HDR1;
      ST_HDR1: if (out_ready) state_d = ST_PAY;
      ST_PAY:  if (pay_fire && pay_last) state_d = ST_TRL;
      ST_TRL:  if (out_ready) begin
        pkt_done = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    cnt_en  = start | pay_fire;
    cnt_d   = start ? '0 : cnt_q + 1'b1;
    mode_en = start;
    mode_d  = full_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mode_en) mode_q <= mode_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/pfmt_hdr.sv
module pfmt_hdr #(
  parameter int W     = 32,
  parameter int EVT_W = 8,
  parameter int BX_W  = 12,
  parameter int DET_W = 4,
  parameter int ST_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             pkt_done,
  input  logic [BX_W-1:0]  bunch_id,
  input  logic [DET_W-1:0] det_id,
  input  logic [ST_W-1:0]  fe_status,
  input  logic             ovf_flag,
  input  logic             mode_q,
  output logic [W-1:0]     hdr0,
  output logic [W-1:0]     hdr1
);
  localparam int FIELDS = EVT_W + BX_W + DET_W + ST_W;
  localparam int H0_PAD = W - FIELDS;

  logic [EVT_W-1:0] evt_q, evt_d;
  logic [BX_W-1:0]  bx_q;
  logic [DET_W-1:0] det_q;
  logic [ST_W-1:0]  st_q;
  logic             ovf_q;
  logic             evt_en;
  logic [FIELDS-1:0] h0_fields;

  always_comb begin
    evt_en = pkt_done;
    evt_d  = evt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
      bx_q  <= '0;
      det_q <= '0;
      st_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (evt_en) evt_q <= evt_d;
      if (cap) begin
        bx_q  <= bunch_id;
        det_q <= det_id;
        st_q  <= fe_status;
        ovf_q <= ovf_flag;
      end
    end
  end

  assign h0_fields = {evt_q, bx_q, det_q, st_q};

  generate
    if (H0_PAD > 0) begin : g_h0_pad
      assign hdr0 = {{H0_PAD{1'b0}}, h0_fields};
    end else begin : g_h0_full
      assign hdr0 = h0_fields[W-1:0];
    end
  endgenerate

  assign hdr1 = {mode_q, ovf_q, {(W-2){1'b0}}};
endmodule

// File: rtl/pfmt_colpar.sv
module pfmt_colpar #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] par
);
  logic [W-1:0] par_q, par_d;
  logic         par_en;

  always_comb begin
    par_en = clr | en;
    par_d  = clr ? '0 : (par_q ^ din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= '0;
    else if (par_en) par_q <= par_d;
  end

  assign par = par_q;
endmodule

// File: rtl/pix_evt_framer.sv
module pix_evt_framer
  import pfmt_pkg::*;
#(
  parameter int W          = 32,
  parameter int NORM_WORDS = 32,
  parameter int FULL_WORDS = 256,
  parameter int EVT_W      = 8,
  parameter int BX_W       = 12,
  parameter int DET_W      = 4,
  parameter int ST_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_mode,
  input  logic [BX_W-1:0]  bunch_id,
  input  logic [DET_W-1:0] det_id,
  input  logic [ST_W-1:0]  fe_status,
  input  logic             ovf_flag,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data,
  output logic             out_sop,
  output logic             out_eop
);
  pfmt_state_e state;
  logic        start, pay_fire, pkt_done, mode_q;
  logic [W-1:0] hdr0, hdr1, par;

  pfmt_ctrl #(.NORM_WORDS(NORM_WORDS), .FULL_WORDS(FULL_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .full_mode(full_mode), .state(state), .start(start), .pay_fire(pay_fire),
    .pkt_done(pkt_done), .mode_q(mode_q)
  );

  pfmt_hdr #(.W(W), .EVT_W(EVT_W), .BX_W(BX_W), .DET_W(DET_W), .ST_W(ST_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap(start), .pkt_done(pkt_done),
    .bunch_id(bunch_id), .det_id(det_id), .fe_status(fe_status),
    .ovf_flag(ovf_flag), .mode_q(mode_q), .hdr0(hdr0), .hdr1(hdr1)
  );

  pfmt_colpar #(.W(W)) u_par (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(pay_fire), .din(in_data), .par(par)
  );

  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    in_ready  = 1'b0;
    case (state)
      ST_HDR0: begin out_valid = 1'b1; out_data = hdr0; end
      ST_HDR1: begin out_valid = 1'b1; out_data = hdr1; end
      ST_PAY:  begin out_valid = in_valid; out_data = in_data; in_ready = out_ready; end
      ST_TRL:  begin out_valid = 1'b1; out_data = par; end
      default: ;
    endcase
    out_sop = (state == ST_HDR0);
    out_eop = (state == ST_TRL);
  end
endmodule

// File: rtl/pfmt_chk.sv
module pfmt_chk #(
  parameter int W          = 32,
  parameter int NORM_WORDS = 32,
  parameter int FULL_WORDS = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_sop,
  input logic         out_eop
);
  logic        out_fire, sop_fire;
  logic [15:0] beats_q;
  logic        h1_pend_q, mode_c_q;

  assign out_fire = out_valid && out_ready;
  assign sop_fire = out_fire && out_sop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_q   <= '0;
      h1_pend_q <= 1'b0;
      mode_c_q  <= 1'b0;
    end else begin
      if (sop_fire) beats_q <= '0;
      else if (in_valid && in_ready) beats_q <= beats_q + 16'd1;
      if (sop_fire) h1_pend_q <= 1'b1;
      else if (out_fire && h1_pend_q) begin
        h1_pend_q <= 1'b0;
        mode_c_q  <= out_data[W-1];
      end
    end
  end

  always_comb begin
    if (!rst_n) begin
      assert_quiet_in_reset_R1: assert (!out_valid && !in_ready);
    end
  end

  assert_idle_after_trailer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_eop) |=> !out_valid);

  assert_hdr1_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sop_fire |=> (out_valid && !out_sop && !out_eop));

  assert_hdr1_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sop_fire |=> (out_data[W-3:0] == '0));

  // R5 and R6: payload length matches the mode carried in header 1
  assert_pay_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eop) |->
      (beats_q == (mode_c_q ? 16'(FULL_WORDS) : 16'(NORM_WORDS))));

  assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  assert_no_marker_in_pay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_sop && !out_eop));
endmodule

bind pix_evt_framer pfmt_chk #(.W(W), .NORM_WORDS(NORM_WORDS), .FULL_WORDS(FULL_WORDS)) u_pfmt_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_sop(out_sop), .out_eop(out_eop)
);

// File: tb/test_pix_evt_framer.sv
module test_pix_evt_framer;
  logic        clk, rst_n;
  logic        full_mode, ovf_flag;
  logic [11:0] bunch_id;
  logic [3:0]  det_id;
  logic [7:0]  fe_status;
  logic        in_valid, in_ready, out_valid, out_ready, out_sop, out_eop;
  logic [31:0] in_data, out_data;

  pix_evt_framer i_pix_evt_framer (
    .clk(clk), .rst_n(rst_n), .full_mode(full_mode), .bunch_id(bunch_id),
    .det_id(det_id), .fe_status(fe_status), .ovf_flag(ovf_flag),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  typedef struct {
    logic [31:0] d;
    logic        sop;
    logic        eop;
    bit          pay;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   evt_model = 0;
  bit   bp_on = 0;
  bit   done = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] gen(int pat, int i);
    case (pat)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h1 << (i % 32);
      3: return (i + 1) * 32'h9E37_79B1;
      default: return (i == 5) ? 32'hFFFF_FFFF : 32'h0;
    endcase
  endfunction

  task automatic send_pkt(bit fm, logic [11:0] bx, logic [3:0] det,
                          logic [7:0] st, bit ovf, int pat);
    int n = fm ? 256 : 32;
    logic [31:0] par = '0;
    exp_t e;
    e.d = {evt_model[7:0], bx, det, st}; e.sop = 1; e.eop = 0; e.pay = 0;
    e.tag = "R3 R8 R9 header0"; q.push_back(e);
    e.d = {fm, ovf, 30'b0}; e.sop = 0; e.tag = "R4 R8 header1"; q.push_back(e);
    for (int i = 0; i < n; i++) begin
      e.d = gen(pat, i); par ^= e.d; e.pay = 1;
      e.tag = fm ? "R6 payload" : "R5 payload"; q.push_back(e);
    end
    e.d = par; e.pay = 0; e.eop = 1; e.tag = "R7 trailer"; q.push_back(e);
    evt_model++;
    full_mode = fm; bunch_id = bx; det_id = det; fe_status = st; ovf_flag = ovf;
    in_valid = 1'b1; in_data = gen(pat, 0);
    forever begin
      @(posedge clk); #1;
      if (out_sop) break;
    end
    // R8: inputs change after the packet has started
    full_mode = ~fm; bunch_id = ~bx; det_id = ~det; fe_status = ~st; ovf_flag = ~ovf;
    for (int i = 0; i < n; i++) begin
      in_data = gen(pat, i);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  // Downstream ready, random when backpressure is enabled
  always @(posedge clk) begin
    #1;
    out_ready <= bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  // Monitor / scoreboard
  logic        stalled = 1'b0;
  logic [31:0] held;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stalled) chk(out_valid && out_data == held, "R10 stall hold", out_data, held);
      if (in_ready) chk(q.size() > 0 && q[0].pay, "R11 ready only in payload", 32'(in_ready), 32'd0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) chk(1'b0, "R2 unexpected word", out_data, 32'h0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(out_data == e.d, e.tag, out_data, e.d);
          chk(out_sop == e.sop && out_eop == e.eop, "R2 markers",
              {30'b0, out_sop, out_eop}, {30'b0, e.sop, e.eop});
        end
      end
      stalled = out_valid && !out_ready;
      held    = out_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; full_mode = 1'b0;
    bunch_id = '0; det_id = '0; fe_status = '0; ovf_flag = 1'b0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !in_ready, "R1 in reset", {30'b0, out_valid, in_ready}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !in_ready, "R1 after reset", {30'b0, out_valid, in_ready}, 32'h0);

    send_pkt(0, 12'hABC, 4'h5, 8'h3C, 0, 2);
    send_pkt(0, 12'h123, 4'hA, 8'hFF, 1, 1);
    send_pkt(0, 12'h7FF, 4'h1, 8'h00, 0, 4);
    send_pkt(1, 12'h456, 4'h9, 8'h81, 1, 3);
    bp_on = 1;
    send_pkt(0, 12'hDEF, 4'h3, 8'h5A, 1, 3);
    send_pkt(1, 12'h001, 4'hF, 8'hA5, 0, 2);
    send_pkt(0, 12'h800, 4'h0, 8'h11, 0, 4);
    bp_on = 0;
    // R9: enough packets to wrap the event count
    for (int k = 0; k < 252; k++)
      send_pkt(k[0], 12'(k * 7), 4'(k), 8'(k * 3), k[1], (k % 5 == 0) ? 3 : 0);
    while (q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0 && !out_valid, "R2 idle at end", {31'b0, out_valid}, 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule